// File: doc/BRIEF.md
# Sub-vector horizontal reduction sequencer

This block walks a vector of elements held in a register file. Each element is a packed group of two, three or four lanes. The sequencer folds the lanes of each element into one scalar using a chosen binary operation. The first operand lane is taken from one source register. The other lanes come from a second source register. The destination register holds the running partial result: the sequencer rewrites it after every fold step, so the destination always shows the state of the fold so far.

A controller starts a job with a one-cycle `start` pulse, with the job's configuration held on the configuration inputs. The sequencer then issues register-file reads and writes until it raises `done` for one cycle. A predicate mask can skip elements. A scalar-destination mode collapses the loop onto the first active element. An optional record mode emits a three-bit sign/zero flag for each element's final result on a separate flag port. Lane k of a source register sits at bits [k*EW +: EW], with lane x at k = 0.

Top module: `hred_seq`

## Requirements
- R1: For each active element i, the first step writes op(A[i].x, B[i].y). Each later step writes op(previous partial, B[i].lane), using lane z and then lane w. A[i] is the register at cfg_ra+i and B[i] is the register at cfg_rb+i.
- R2: cfg_op selects the operation: 0 is wrapping add, 1 is AND, 2 is OR, 3 is XOR, 4 is signed minimum and 5 is signed maximum.
- R3: cfg_subvl gives the lane count minus one (1 = two lanes, 2 = three lanes, 3 = four lanes). Each active element produces exactly cfg_subvl writes. Every written word carries the EW-bit partial result in its low bits, with all upper bits zero.
- R4: In vector mode, element i writes register cfg_rt+i. All register indices wrap modulo NREG. The destination may be the same register range as source A.
- R5: When cfg_pred_en is 1, an element whose cfg_mask bit is 0 produces no register write and no flag write. When cfg_pred_en is 0, every element below cfg_vl is active.
- R6: When cfg_dst_scalar is 1, every write goes to cfg_rt, and the job ends after the first active element. That is element 0 when unpredicated.
- R7: When cfg_rec is 1, the final step of each active element also writes flag entry i with {negative, positive, zero} of the signed result. When cfg_rec is 0, no flag writes occur.
- R8: A start with cfg_subvl = 0 or cfg_op above 5 performs no writes. `done` and `cfg_err` are then both high in the cycle after start.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start up to and including the `done` cycle. A start while busy is ignored.
- R10: A job with cfg_vl = 0 performs no writes and ends with `done` and no error.
- R11: After reset, `busy`, `done`, `cfg_err`, `rf_we` and `fl_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (ignored while busy) |
| cfg_vl | input | VLW | Element count, 0 to MAX_VL |
| cfg_subvl | input | 2 | Lanes per element minus one |
| cfg_op | input | 3 | Fold operation code |
| cfg_pred_en | input | 1 | Enable the predicate mask |
| cfg_mask | input | MAX_VL | Per-element predicate bits |
| cfg_dst_scalar | input | 1 | Destination is a single register |
| cfg_rec | input | 1 | Emit flags for each result |
| cfg_ra | input | AW | Base register of source A |
| cfg_rb | input | AW | Base register of source B |
| cfg_rt | input | AW | Base register of the destination |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| cfg_err | output | 1 | Job rejected, valid with done |
| rf_raddr_a | output | AW | Source A read address |
| rf_rdata_a | input | EW | Lane x of the register read at port A (one-cycle latency) |
| rf_raddr_b | output | AW | Source B read address |
| rf_rdata_b | input | 4*EW | Whole register read at port B (one-cycle latency) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | AW | Register write address |
| rf_wdata | output | 4*EW | Register write data |
| fl_we | output | 1 | Flag write strobe |
| fl_idx | output | VLW | Flag entry index |
| fl_val | output | 3 | {negative, positive, zero} |

## Verification
The bound assertions watch properties that hold on every cycle:
- `done` is a single-cycle pulse, and writes occur only while busy.
- Rejected configurations finish in one cycle with no writes.
- Flag words are one-hot, coincide with a register write, and agree with that write's zero test.
- Written words keep their upper bits clear.

Only the bench's scenarios can show the arithmetic of each fold chain. The same holds for the order of lanes, address wrap-around, skipped elements leaving registers untouched, the early stop of the scalar mode, and the exact number of writes per element. The bench shows these by comparing a modelled register file and flag array after each job.

// File: rtl/hred_pkg.sv
package hred_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_AND  = 3'd1,
      OP_OR   = 3'd2,
      OP_XOR  = 3'd3,
      OP_SMIN = 3'd4,
      OP_SMAX = 3'd5
   } red_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEEK,
      ST_FOLD,
      ST_FIN
   } seq_st_e;

   localparam int LANES_MAX = 4;
endpackage

// File: rtl/hred_alu.sv
module hred_alu #(
   parameter int EW         = 16,
   parameter bit USE_MINMAX = 1'b1
) (
   input  logic [2:0]    op,
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   output logic [EW-1:0] y
);
   import hred_pkg::*;

   logic [EW-1:0] mn, mx;

   generate
      if (USE_MINMAX) begin : g_minmax
         logic a_lt;
         assign a_lt = $signed(a) < $signed(b);
         assign mn   = a_lt ? a : b;
         assign mx   = a_lt ? b : a;
      end else begin : g_nominmax
         assign mn = '0;
         assign mx = '0;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_SMIN: y = mn;
         OP_SMAX: y = mx;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/hred_flag.sv
module hred_flag #(
   parameter int EW = 16
) (
   input  logic [EW-1:0] v,
   output logic [2:0]    flags
);
   logic neg, zer;
   assign neg   = v[EW-1];
   assign zer   = (v == '0);
   assign flags = {neg, ~neg & ~zer, zer};
endmodule

// File: rtl/hred_ctrl.sv
module hred_ctrl #(
   parameter int MAX_VL     = 8,
   parameter bit USE_MINMAX = 1'b1,
   parameter int VLW        = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    cfg_vl,
   input  logic [1:0]        cfg_subvl,
   input  logic [2:0]        cfg_op,
   input  logic              cfg_pred_en,
   input  logic [MAX_VL-1:0] cfg_mask,
   input  logic              cfg_dst_scalar,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              accept,
   output logic [VLW-1:0]    elem,
   output logic [1:0]        lane,
   output logic [2:0]        op_q,
   output logic              scal_q,
   output logic              step_act,
   output logic              step_first,
   output logic              step_last
);
   import hred_pkg::*;

   localparam int          MW     = 1 << VLW;
   localparam logic [2:0]  OP_LIM = USE_MINMAX ? 3'd6 : 3'd4;

   seq_st_e           st;
   logic [VLW-1:0]    vl_q;
   logic [1:0]        subvl_q;
   logic [MAX_VL-1:0] mask_q;
   logic              err_q;
   logic [MW-1:0]     mask_x;
   logic              bad_cfg;
   logic              in_range;

   assign accept   = start && (st == ST_IDLE);
   assign bad_cfg  = (cfg_subvl == 2'd0) || (cfg_op >= OP_LIM);
   assign mask_x   = MW'(mask_q);
   assign in_range = elem < vl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         vl_q    <= '0;
         subvl_q <= '0;
         op_q    <= '0;
         mask_q  <= '0;
         scal_q  <= 1'b0;
         err_q   <= 1'b0;
         elem    <= '0;
         lane    <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  vl_q    <= cfg_vl;
                  subvl_q <= cfg_subvl;
                  op_q    <= cfg_op;
                  mask_q  <= cfg_pred_en ? cfg_mask : '1;
                  scal_q  <= cfg_dst_scalar;
                  err_q   <= bad_cfg;
                  elem    <= '0;
                  lane    <= '0;
                  st      <= bad_cfg ? ST_FIN : ST_SEEK;
               end
            end
            ST_SEEK: begin
               if (!in_range) begin
                  st <= ST_FIN;
               end else if (mask_x[elem]) begin
                  lane <= 2'd1;
                  st   <= ST_FOLD;
               end else begin
                  elem <= elem + 1'b1;
               end
            end
            ST_FOLD: begin
               if (lane == subvl_q) begin
                  if (scal_q) begin
                     st <= ST_FIN;
                  end else begin
                     elem <= elem + 1'b1;
                     st   <= ST_SEEK;
                  end
               end else begin
                  lane <= lane + 1'b1;
               end
            end
            ST_FIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign done       = (st == ST_FIN);
   assign err        = done && err_q;
   assign step_act   = (st == ST_FOLD);
   assign step_first = (lane == 2'd1);
   assign step_last  = (lane == subvl_q);
endmodule

// File: rtl/hred_seq.sv
module hred_seq #(
   parameter int EW         = 16,
   parameter int NREG       = 32,
   parameter int MAX_VL     = 8,
   parameter bit USE_MINMAX = 1'b1,
   parameter int AW         = $clog2(NREG),
   parameter int VLW        = $clog2(MAX_VL + 1),
   parameter int RW         = hred_pkg::LANES_MAX * EW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    cfg_vl,
   input  logic [1:0]        cfg_subvl,
   input  logic [2:0]        cfg_op,
   input  logic              cfg_pred_en,
   input  logic [MAX_VL-1:0] cfg_mask,
   input  logic              cfg_dst_scalar,
   input  logic              cfg_rec,
   input  logic [AW-1:0]     cfg_ra,
   input  logic [AW-1:0]     cfg_rb,
   input  logic [AW-1:0]     cfg_rt,
   output logic              busy,
   output logic              done,
   output logic              cfg_err,
   output logic [AW-1:0]     rf_raddr_a,
   input  logic [EW-1:0]     rf_rdata_a,
   output logic [AW-1:0]     rf_raddr_b,
   input  logic [RW-1:0]     rf_rdata_b,
   output logic              rf_we,
   output logic [AW-1:0]     rf_waddr,
   output logic [RW-1:0]     rf_wdata,
   output logic              fl_we,
   output logic [VLW-1:0]    fl_idx,
   output logic [2:0]        fl_val
);
   import hred_pkg::*;

   generate
      if (EW < 2)            begin : g_chk_ew  $error("EW must be at least 2");           end
      if ((1 << AW) != NREG) begin : g_chk_nr  $error("NREG must be a power of two");     end
      if (MAX_VL < 1)        begin : g_chk_vl  $error("MAX_VL must be at least 1");       end
      if (MAX_VL > NREG)     begin : g_chk_vr  $error("MAX_VL must not exceed NREG");     end
   endgenerate

   logic           accept;
   logic [VLW-1:0] elem;
   logic [1:0]     lane;
   logic [2:0]     op_q;
   logic           scal_q, step_act, step_first, step_last;
   logic [AW-1:0]  ra_q, rb_q, rt_q;
   logic           rec_q;
   logic [EW-1:0]  acc_q;
   logic [EW-1:0]  b_lane [LANES_MAX];
   logic [EW-1:0]  opnd_a, opnd_b, res;

   hred_ctrl #(
      .MAX_VL(MAX_VL), .USE_MINMAX(USE_MINMAX), .VLW(VLW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_vl(cfg_vl), .cfg_subvl(cfg_subvl), .cfg_op(cfg_op),
      .cfg_pred_en(cfg_pred_en), .cfg_mask(cfg_mask),
      .cfg_dst_scalar(cfg_dst_scalar),
      .busy(busy), .done(done), .err(cfg_err), .accept(accept),
      .elem(elem), .lane(lane), .op_q(op_q), .scal_q(scal_q),
      .step_act(step_act), .step_first(step_first), .step_last(step_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra_q  <= '0;
         rb_q  <= '0;
         rt_q  <= '0;
         rec_q <= 1'b0;
      end else if (accept) begin
         ra_q  <= cfg_ra;
         rb_q  <= cfg_rb;
         rt_q  <= cfg_rt;
         rec_q <= cfg_rec;
      end
   end

   assign rf_raddr_a = ra_q + AW'(elem);
   assign rf_raddr_b = rb_q + AW'(elem);

   for (genvar k = 0; k < LANES_MAX; k++) begin : g_lane
      assign b_lane[k] = rf_rdata_b[k*EW +: EW];
   end

   assign opnd_a = step_first ? rf_rdata_a : acc_q;
   assign opnd_b = b_lane[lane];

   hred_alu #(.EW(EW), .USE_MINMAX(USE_MINMAX)) u_alu (
      .op(op_q), .a(opnd_a), .b(opnd_b), .y(res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q <= '0;
      else if (step_act) acc_q <= res;
   end

   assign rf_we    = step_act;
   assign rf_waddr = scal_q ? rt_q : rt_q + AW'(elem);
   assign rf_wdata = RW'(res);

   hred_flag #(.EW(EW)) u_flag (.v(res), .flags(fl_val));

   assign fl_we  = step_act && step_last && rec_q;
   assign fl_idx = elem;
endmodule

// File: rtl/hred_chk.sv
module hred_chk #(
   parameter int EW         = 16,
   parameter int MAX_VL     = 8,
   parameter bit USE_MINMAX = 1'b1,
   parameter int RW         = 4 * EW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [1:0]    cfg_subvl,
   input logic [2:0]    cfg_op,
   input logic          busy,
   input logic          done,
   input logic          cfg_err,
   input logic          rf_we,
   input logic [RW-1:0] rf_wdata,
   input logic          fl_we,
   input logic [2:0]    fl_val
);
   logic reject;
   assign reject = (cfg_subvl == 2'd0) || (cfg_op > (USE_MINMAX ? 3'd5 : 3'd3));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rf_we && !fl_we));
   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> done);
   p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && reject) |=> (done && cfg_err && !rf_we));
   p_flag_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we |-> ($onehot(fl_val) && rf_we));
   p_flag_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we |-> (fl_val[0] == (rf_wdata == '0)));
   p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_wdata[RW-1:EW] == '0));
endmodule

bind hred_seq hred_chk #(
   .EW(EW), .MAX_VL(MAX_VL), .USE_MINMAX(USE_MINMAX), .RW(RW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cfg_subvl(cfg_subvl),
   .cfg_op(cfg_op), .busy(busy), .done(done), .cfg_err(cfg_err),
   .rf_we(rf_we), .rf_wdata(rf_wdata), .fl_we(fl_we), .fl_val(fl_val)
);

// File: tb/sim_hred_seq.sv
`timescale 1ns/1ps
module sim_hred_seq;
   localparam int EW = 16, NREG = 32, MAX_VL = 8;
   localparam int AW = 5, VLW = 4, RW = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              start = 0;
   logic [VLW-1:0]    cfg_vl = 0;
   logic [1:0]        cfg_subvl = 0;
   logic [2:0]        cfg_op = 0;
   logic              cfg_pred_en = 0, cfg_dst_scalar = 0, cfg_rec = 0;
   logic [MAX_VL-1:0] cfg_mask = 0;
   logic [AW-1:0]     cfg_ra = 0, cfg_rb = 0, cfg_rt = 0;
   logic              busy, done, cfg_err, rf_we, fl_we;
   logic [AW-1:0]     rf_raddr_a, rf_raddr_b, rf_waddr;
   logic [EW-1:0]     rf_rdata_a;
   logic [RW-1:0]     rf_rdata_b, rf_wdata;
   logic [VLW-1:0]    fl_idx;
   logic [2:0]        fl_val;

   hred_seq u0 (.*);

   // register file and flag model
   logic [RW-1:0] mem [NREG];
   logic [2:0]    flg [MAX_VL];
   int            wr_cnt, fl_cnt;
   logic          ld_en = 0, clr = 0;
   logic [AW-1:0] ld_addr = 0;
   logic [RW-1:0] ld_data = 0;

   always @(posedge clk) begin
      rf_rdata_a <= mem[rf_raddr_a][EW-1:0];
      rf_rdata_b <= mem[rf_raddr_b];
      if (ld_en) mem[ld_addr] <= ld_data;
      if (rf_we) begin mem[rf_waddr] <= rf_wdata; wr_cnt <= wr_cnt + 1; end
      if (fl_we) begin flg[fl_idx[2:0]] <= fl_val; fl_cnt <= fl_cnt + 1; end
      if (clr) begin
         for (int k = 0; k < MAX_VL; k++) flg[k] <= 3'b000;
         wr_cnt <= 0;
         fl_cnt <= 0;
      end
   end

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [RW-1:0] em [NREG];
   logic [2:0]    ef [MAX_VL];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [EW-1:0] mop(input logic [2:0] op, input logic [EW-1:0] a, input logic [EW-1:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a & b;
         3'd2: return a | b;
         3'd3: return a ^ b;
         3'd4: return ($signed(a) < $signed(b)) ? a : b;
         3'd5: return ($signed(a) > $signed(b)) ? a : b;
         default: return '0;
      endcase
   endfunction

   function automatic logic [2:0] mflag(input logic [EW-1:0] v);
      logic n, z;
      n = v[EW-1];
      z = (v == 0);
      return {n, !n && !z, z};
   endfunction

   function automatic logic [EW-1:0] rlane(input int mode);
      logic [EW-1:0] v;
      v = EW'($urandom);
      if (mode == 1) v = v & 16'h0003;
      return v;
   endfunction

   task automatic fill(input int mode);
      for (int r = 0; r < NREG; r++) begin
         logic [RW-1:0] d;
         d = {rlane(mode), rlane(mode), rlane(mode), rlane(mode)};
         em[r] = d;
         @(negedge clk);
         ld_en = 1; ld_addr = AW'(r); ld_data = d;
      end
      @(negedge clk);
      ld_en = 0; clr = 1;
      @(negedge clk);
      clr = 0;
      for (int k = 0; k < MAX_VL; k++) ef[k] = 3'b000;
   endtask

   task automatic job(input string tag, input int vl, input int sv, input int op,
                      input bit pe, input logic [MAX_VL-1:0] mk, input bit sc,
                      input bit rc, input int ra, input int rb, input int rt,
                      input bit restart, input int mode);
      int ew, efn, wait_n;
      bit bad, seen_err;
      int nbad;
      fill(mode);
      bad = (sv == 0) || (op > 5);
      ew = 0;
      efn = 0;
      if (!bad) begin
         for (int i = 0; i < vl; i++) begin
            logic [RW-1:0] ar, br;
            logic [EW-1:0] acc;
            int dst;
            if (pe && !mk[i]) continue;
            ar  = em[(ra + i) % NREG];
            br  = em[(rb + i) % NREG];
            dst = sc ? rt : (rt + i) % NREG;
            acc = mop(3'(op), ar[EW-1:0], br[EW +: EW]);
            em[dst] = RW'(acc);
            ew++;
            for (int l = 2; l <= sv; l++) begin
               acc = mop(3'(op), acc, br[l*EW +: EW]);
               em[dst] = RW'(acc);
               ew++;
            end
            if (rc) begin ef[i] = mflag(acc); efn++; end
            if (sc) break;
         end
      end
      @(negedge clk);
      cfg_vl = VLW'(vl); cfg_subvl = 2'(sv); cfg_op = 3'(op); cfg_pred_en = pe;
      cfg_mask = mk; cfg_dst_scalar = sc; cfg_rec = rc;
      cfg_ra = AW'(ra); cfg_rb = AW'(rb); cfg_rt = AW'(rt);
      start = 1;
      @(negedge clk);
      chk({tag, " R9 busy after start"}, 64'(busy), 64'd1);
      if (restart) begin
         cfg_op = 3'(op ^ 1); cfg_rt = AW'(rt + 3); cfg_vl = VLW'(MAX_VL);
      end else begin
         start = 0;
      end
      wait_n = 0;
      while (!done && wait_n < 200) begin
         @(negedge clk);
         start = 0;
         wait_n++;
      end
      start = 0;
      seen_err = cfg_err;
      chk({tag, " R8 error flag"}, 64'(seen_err), 64'(bad));
      @(negedge clk);
      chk({tag, " R9 done single cycle"}, 64'({done, busy}), 64'd0);
      nbad = 0;
      for (int r = 0; r < NREG; r++) if (mem[r] !== em[r]) nbad++;
      chk({tag, " R1 R4 register contents mismatches"}, 64'(nbad), 64'd0);
      chk({tag, " R3 write count"}, 64'(wr_cnt), 64'(ew));
      nbad = 0;
      for (int k = 0; k < MAX_VL; k++) if (flg[k] !== ef[k]) nbad++;
      chk({tag, " R7 flag entries mismatches"}, 64'(nbad), 64'd0);
      chk({tag, " R7 flag write count"}, 64'(fl_cnt), 64'(efn));
   endtask

   initial begin
      for (int r = 0; r < NREG; r++) mem[r] = '0;
      for (int k = 0; k < MAX_VL; k++) flg[k] = '0;
      wr_cnt = 0; fl_cnt = 0;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      chk("R11 reset outputs", 64'({busy, done, cfg_err, rf_we, fl_we}), 64'd0);
      rst_n = 1;
      @(negedge clk);
      // R2: each operation on four-lane elements
      for (int op = 0; op < 6; op++) job("R2 op", 5, 3, op, 0, 0, 0, 1, 0, 16, 8, 0, 0);
      // R3: each lane count
      job("R3 vec2", 8, 1, 0, 0, 0, 0, 0, 0, 16, 8, 0, 0);
      job("R3 vec3", 8, 2, 5, 0, 0, 0, 1, 0, 16, 8, 0, 0);
      // R4: destination equals source A, and wrap-around
      job("R4 rt eq ra", 8, 3, 0, 0, 0, 0, 1, 4, 20, 4, 0, 0);
      job("R4 wrap", 8, 2, 3, 0, 0, 0, 1, 30, 14, 27, 0, 0);
      // R5: predicate mask
      job("R5 mask", 8, 3, 4, 1, 8'b1010_0110, 0, 1, 0, 16, 8, 0, 0);
      job("R5 empty mask", 8, 3, 0, 1, 8'b0, 0, 1, 0, 16, 8, 0, 0);
      // R6: scalar destination
      job("R6 scalar unpred", 8, 3, 0, 0, 0, 1, 1, 0, 16, 8, 0, 0);
      job("R6 scalar pred", 8, 2, 2, 1, 8'b0010_1000, 1, 1, 0, 16, 8, 0, 0);
      // R7: zero results from small operands
      job("R7 zeros", 8, 3, 1, 0, 0, 0, 1, 0, 16, 8, 0, 1);
      job("R7 zero xor", 8, 1, 3, 0, 0, 0, 1, 0, 16, 8, 0, 1);
      // R8: rejected configurations
      job("R8 subvl0", 4, 0, 0, 0, 0, 0, 1, 0, 16, 8, 0, 0);
      job("R8 op6", 4, 3, 6, 0, 0, 0, 1, 0, 16, 8, 0, 0);
      job("R8 op7", 4, 3, 7, 0, 0, 0, 1, 0, 16, 8, 0, 0);
      // R9: start held while busy is ignored
      job("R9 restart", 6, 3, 0, 0, 0, 0, 1, 0, 16, 8, 1, 0);
      // R10: zero length
      job("R10 vl0", 0, 3, 0, 0, 0, 0, 1, 0, 16, 8, 0, 0);
      // R1: random mix
      for (int n = 0; n < 40; n++) begin
         int rt, sc;
         rt = int'($urandom_range(0, 31));
         sc = int'($urandom_range(0, 3) == 0);
         job("R1 random", int'($urandom_range(0, 8)), int'($urandom_range(1, 3)),
             int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)), MAX_VL'($urandom),
             bit'(sc), bit'($urandom_range(0, 1)),
             ($urandom_range(0, 1) != 0) ? rt : int'($urandom_range(0, 31)),
             (rt + 16) % NREG, rt, 0, int'($urandom_range(0, 1)));
      end
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule